// File: doc/BRIEF.md
# SPI Slave RAM Access Bridge

This block lets an external SPI master read and write an on-chip RAM directly, without any processor involvement. Each transfer opens with a command byte and a 16-bit start address. Data bytes then stream into or out of the RAM, and the RAM pointer moves forward one step per byte. The two upper command bits choose a RAM write, a RAM read, or a mailbox command. A mailbox command touches no RAM. Instead it leaves its command and address in registers that the host processor can read.

All SPI pins pass through two-flop synchronizers and are sampled by the system clock. The system clock must run at least four times faster than the serial clock. The bus runs in SPI mode 0, most significant bit first. The master samples on the rising serial clock edge, and the block changes its output on the falling edge. When a transfer qualifies, a one-cycle host interrupt pulse follows the rise of chip select.

The RAM is synchronous and single-port. It returns read data on the clock cycle after the read strobe.

Top module: `spi_ram_bridge`

## Requirements
- R1: While `spi_csn` is high, `spi_miso_oe` is low. Clock and data-in activity then causes no RAM strobe and no interrupt.
- R2: Bits are taken MSB first on rising `spi_sck`. The first 8 bits after `spi_csn` falls form the command, and the next 16 bits form the address.
- R3: A command whose bits [7:6] are 2'b10 writes each complete received data byte to RAM. The first byte goes to the given address.
- R4: A command whose bits [7:6] are 2'b11 shifts RAM bytes out on `spi_miso`, MSB first. The first byte comes from the given address, and its MSB is valid from the falling edge that follows the last address bit.
- R5: During a read or write, the RAM address advances by one per data byte and wraps from 0xFFFF to 0x0000.
- R6: A read or write raises the interrupt only if command bits [5:0] are nonzero. Commands 0x80 and 0xC0 raise none.
- R7: A command with bit 7 = 0 is a mailbox. It loads `host_cmd` and `host_addr`, writes no RAM even when data bytes follow, and always raises the interrupt.
- R8: `host_irq` is a pulse exactly one system clock long, issued after `spi_csn` rises, at most once per transfer.
- R9: If chip select rises in the middle of a data byte of a write, the incomplete byte is not stored.
- R10: A mailbox transfer that holds only a command byte is legal. It updates `host_cmd`, leaves `host_addr` unchanged and raises the interrupt.
- R11: `ram_we` and `ram_re` are never high together, and `ram_we` is issued only for write commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master (value) |
| spi_miso_oe | output | 1 | Output enable for the `spi_miso` pad driver |
| ram_addr | output | 16 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_rdata | input | 8 | RAM read data, valid one cycle after `ram_re` |
| host_cmd | output | 8 | Last mailbox command |
| host_addr | output | 16 | Last mailbox address |
| host_irq | output | 1 | Host interrupt pulse |

## Verification
The assertions check four properties on every cycle. The output enable is released while chip select is inactive. RAM strobes stay quiet across idle cycles. Writes never coincide with reads, and never appear under a non-write command. The interrupt is a lone pulse that directly follows the end of a transfer. The scenarios alone must show the things that depend on whole transfers. These are the data values that land in RAM or come back out of it, the address stepping and its wrap at 0xFFFF, the choice of interrupt by the command's low six bits, the mailbox registers, and the dropped partial byte.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;
  localparam int CMD_W  = 8;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 16;

  typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_DATA} phase_t;
  typedef enum logic [1:0] {K_MBOX, K_WRITE, K_READ} kind_t;

  // command class from the two upper bits
  function automatic kind_t decode_kind(input logic [CMD_W-1:0] c);
    if (!c[CMD_W-1])     return K_MBOX;
    else if (c[CMD_W-2]) return K_READ;
    else                 return K_WRITE;
  endfunction

  // mailbox always interrupts; RAM commands only with nonzero low bits
  function automatic logic irq_wanted(input logic [CMD_W-1:0] c);
    return !c[CMD_W-1] || (c[CMD_W-3:0] != '0);
  endfunction

  // address step with natural wrap
  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              cs_end,
  input  logic              sck_rise,
  input  logic              mosi,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [BYTE_W-1:0] ram_wdata,
  output logic              ram_we,
  output logic              ram_re,
  output logic              byte_start,
  output logic              rd_mode,
  output logic [CMD_W-1:0]  host_cmd,
  output logic [ADDR_W-1:0] host_addr,
  output logic              irq
);
  localparam int CNT_W = $clog2(ADDR_W);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(BYTE_W - 1);

  phase_t            phase;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] sh;
  logic [ADDR_W-1:0] sh_next;
  logic [CMD_W-1:0]  cmd_q;
  logic              cmd_ok;
  logic [ADDR_W-1:0] ptr;
  kind_t             kind_q;
  kind_t             kind_new;

  // named events
  logic ev_cmd_done, ev_addr_done, ev_byte_done, ev_field_done;

  always_comb begin
    sh_next       = {sh[ADDR_W-2:0], mosi};
    kind_q        = decode_kind(cmd_q);
    kind_new      = decode_kind(sh_next[CMD_W-1:0]);
    ev_cmd_done   = sck_rise && (phase == PH_CMD)  && (cnt == CMD_LAST);
    ev_addr_done  = sck_rise && (phase == PH_ADDR) && (cnt == ADDR_LAST);
    ev_byte_done  = sck_rise && (phase == PH_DATA) && (cnt == BYTE_LAST);
    ev_field_done = ev_cmd_done || ev_addr_done || ev_byte_done;
    byte_start    = (phase == PH_DATA) && (cnt == '0);
    rd_mode       = cs_act && (phase == PH_DATA) && (kind_q == K_READ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_CMD;
      cnt       <= '0;
      sh        <= '0;
      cmd_q     <= '0;
      cmd_ok    <= 1'b0;
      ptr       <= '0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      ram_we    <= 1'b0;
      ram_re    <= 1'b0;
      host_cmd  <= '0;
      host_addr <= '0;
      irq       <= 1'b0;
    end else begin
      ram_we <= 1'b0;
      ram_re <= 1'b0;
      irq    <= 1'b0;
      if (cs_end) irq <= cmd_ok && irq_wanted(cmd_q);
      if (!cs_act) begin
        phase  <= PH_CMD;
        cnt    <= '0;
        sh     <= '0;
        cmd_ok <= 1'b0;
      end else if (sck_rise) begin
        sh  <= sh_next;
        cnt <= ev_field_done ? '0 : cnt + 1'b1;
        unique case (phase)
          PH_CMD: if (ev_cmd_done) begin
            cmd_q  <= sh_next[CMD_W-1:0];
            cmd_ok <= 1'b1;
            phase  <= PH_ADDR;
            if (kind_new == K_MBOX) host_cmd <= sh_next[CMD_W-1:0];
          end
          PH_ADDR: if (ev_addr_done) begin
            phase <= PH_DATA;
            if (kind_q == K_MBOX) host_addr <= sh_next;
            if (kind_q == K_READ) begin
              ram_addr <= sh_next;
              ram_re   <= 1'b1;
              ptr      <= addr_step(sh_next);
            end else begin
              ptr <= sh_next;
            end
          end
          PH_DATA: if (ev_byte_done) begin
            if (kind_q == K_WRITE) begin
              ram_addr  <= ptr;
              ram_wdata <= sh_next[BYTE_W-1:0];
              ram_we    <= 1'b1;
              ptr       <= addr_step(ptr);
            end else if (kind_q == K_READ) begin
              ram_addr <= ptr;
              ram_re   <= 1'b1;
              ptr      <= addr_step(ptr);
            end
          end
          default: phase <= PH_CMD;
        endcase
      end
    end
  end

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && ram_re));
  assert_we_kind_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (kind_q == K_WRITE));
  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_irq_after_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(cs_end));
endmodule

// File: rtl/spi_txpath.sv
module spi_txpath
  import spi_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sck_fall,
  input  logic              byte_start,
  input  logic              rd_mode,
  input  logic              ram_re,
  input  logic [BYTE_W-1:0] ram_rdata,
  output logic              tx_bit,
  output logic              drive
);
  logic              rd_pend;
  logic [BYTE_W-1:0] pf_buf;
  logic [BYTE_W-1:0] tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      pf_buf  <= '0;
      tx_sh   <= '0;
      drive   <= 1'b0;
    end else begin
      rd_pend <= ram_re;
      if (rd_pend) pf_buf <= ram_rdata;
      if (!cs_act) begin
        tx_sh <= '0;
        drive <= 1'b0;
      end else begin
        drive <= rd_mode;
        if (sck_fall && rd_mode)
          tx_sh <= byte_start ? pf_buf : {tx_sh[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign tx_bit = tx_sh[BYTE_W-1];

  assert_quiet_pin_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !drive);
endmodule

// File: rtl/spi_ram_bridge.sv
module spi_ram_bridge
  import spi_bridge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_csn,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [BYTE_W-1:0] ram_wdata,
  output logic              ram_we,
  output logic              ram_re,
  input  logic [BYTE_W-1:0] ram_rdata,
  output logic [CMD_W-1:0]  host_cmd,
  output logic [ADDR_W-1:0] host_addr,
  output logic              host_irq
);
  logic csn_s, sck_s, mosi_s;
  logic csn_prev, sck_prev;
  logic cs_act, cs_end, sck_rise, sck_fall;
  logic byte_start, rd_mode, tx_bit, drive;

  spi_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_csn (
    .clk(clk), .rst_n(rst_n), .d(spi_csn), .q(csn_s));
  spi_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
    .clk(clk), .rst_n(rst_n), .d(spi_sck), .q(sck_s));
  spi_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
    .clk(clk), .rst_n(rst_n), .d(spi_mosi), .q(mosi_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_prev <= 1'b1;
      sck_prev <= 1'b0;
    end else begin
      csn_prev <= csn_s;
      sck_prev <= sck_s;
    end
  end

  always_comb begin
    cs_act   = !csn_s;
    cs_end   = csn_s && !csn_prev;
    sck_rise = cs_act && sck_s && !sck_prev;
    sck_fall = cs_act && !sck_s && sck_prev;
  end

  spi_frame u_frame (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_end(cs_end),
    .sck_rise(sck_rise), .mosi(mosi_s),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_re(ram_re),
    .byte_start(byte_start), .rd_mode(rd_mode),
    .host_cmd(host_cmd), .host_addr(host_addr), .irq(host_irq));

  spi_txpath u_tx (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_fall(sck_fall),
    .byte_start(byte_start), .rd_mode(rd_mode), .ram_re(ram_re),
    .ram_rdata(ram_rdata), .tx_bit(tx_bit), .drive(drive));

  assign spi_miso    = tx_bit;
  assign spi_miso_oe = drive && !spi_csn;

  assert_idle_no_ram_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && $past(!cs_act)) |-> (!ram_we && !ram_re));
endmodule

// File: tb/spi_ram_bridge_test.sv
module spi_ram_bridge_test;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_csn = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata, ram_rdata;
  logic ram_we, ram_re;
  logic [7:0]  host_cmd;
  logic [15:0] host_addr;
  logic host_irq;

  always #2 clk = ~clk;

  spi_ram_bridge uut (
    .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_re(ram_re),
    .ram_rdata(ram_rdata), .host_cmd(host_cmd), .host_addr(host_addr),
    .host_irq(host_irq));

  logic [7:0] mem [256];
  logic [15:0] wa [32];
  logic [7:0]  wd [32];
  int wn = 0, rn = 0, irq_hi = 0, irq_rise = 0, both = 0;
  logic irq_d = 1'b0;
  int checks = 0, errors = 0;
  bit done = 0;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    ram_rdata = 8'h00;
  end

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr[7:0]] <= ram_wdata;
    if (ram_re) ram_rdata <= mem[ram_addr[7:0]];
    if (ram_we && wn < 32) begin wa[wn] = ram_addr; wd[wn] = ram_wdata; wn++; end
    if (ram_re) rn++;
    if (ram_we && ram_re) both++;
    if (host_irq) irq_hi++;
    if (host_irq && !irq_d) irq_rise++;
    irq_d = host_irq;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic half;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = tx[i];
      half();
      rx[i] = spi_miso;
      spi_sck = 1'b1;
      half();
      spi_sck = 1'b0;
    end
  endtask

  task automatic xbits(input logic [7:0] tx, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      spi_mosi = tx[i];
      half();
      spi_sck = 1'b1;
      half();
      spi_sck = 1'b0;
    end
  endtask

  task automatic open_tx;
    spi_csn = 1'b0;
    half();
  endtask

  task automatic close_tx;
    half();
    spi_csn = 1'b1;
    repeat (24) @(negedge clk);
    chk("R1 oe after close", spi_miso_oe, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1 reset oe", spi_miso_oe, 1'b0);
    chk("R8 reset irq", host_irq, 1'b0);
    chk("R7 reset host_cmd", host_cmd, 8'h00);
    chk("R7 reset host_addr", host_addr, 16'h0000);
  endtask

  task automatic t_write_quiet;
    logic [7:0] r;
    int w0 = wn, i0 = irq_rise;
    open_tx(); xfer(8'h80, r); xfer(8'h00, r); xfer(8'h10, r);
    xfer(8'hA5, r); xfer(8'h3C, r); xfer(8'h7E, r);
    close_tx();
    chk("R3 write count", wn - w0, 3);
    chk("R3 addr0", wa[w0], 16'h0010);
    chk("R3 data0", wd[w0], 8'hA5);
    chk("R5 addr1", wa[w0+1], 16'h0011);
    chk("R3 data1", wd[w0+1], 8'h3C);
    chk("R5 addr2", wa[w0+2], 16'h0012);
    chk("R3 data2", wd[w0+2], 8'h7E);
    chk("R6 no irq for 0x80", irq_rise - i0, 0);
  endtask

  task automatic t_read_quiet;
    logic [7:0] r, b0, b1, b2;
    int w0 = wn, i0 = irq_rise;
    open_tx(); xfer(8'hC0, r); xfer(8'h00, r); xfer(8'h10, r);
    xfer(8'h00, b0);
    chk("R4 oe during read", spi_miso_oe, 1'b1);
    xfer(8'h00, b1); xfer(8'h00, b2);
    close_tx();
    chk("R4 byte0", b0, 8'hA5);
    chk("R5 byte1", b1, 8'h3C);
    chk("R5 byte2", b2, 8'h7E);
    chk("R6 no irq for 0xC0", irq_rise - i0, 0);
    chk("R11 no write in read", wn - w0, 0);
  endtask

  task automatic t_write_wrap;
    logic [7:0] r;
    int w0 = wn, i0 = irq_rise, h0 = irq_hi;
    open_tx(); xfer(8'h81, r); xfer(8'hFF, r); xfer(8'hFF, r);
    xfer(8'h11, r); xfer(8'h22, r);
    close_tx();
    chk("R5 wrap first", wa[w0], 16'hFFFF);
    chk("R5 wrap second", wa[w0+1], 16'h0000);
    chk("R3 wrap data", wd[w0+1], 8'h22);
    chk("R6 irq for 0x81", irq_rise - i0, 1);
    chk("R8 one cycle", irq_hi - h0, 1);
  endtask

  task automatic t_read_wrap;
    logic [7:0] r, b0, b1;
    int i0 = irq_rise, h0 = irq_hi;
    open_tx(); xfer(8'hFF, r); xfer(8'hFF, r); xfer(8'hFF, r);
    xfer(8'h00, b0); xfer(8'h00, b1);
    close_tx();
    chk("R4 read at FFFF", b0, 8'h11);
    chk("R5 read wraps", b1, 8'h22);
    chk("R6 irq for 0xFF", irq_rise - i0, 1);
    chk("R8 one cycle read", irq_hi - h0, 1);
  endtask

  task automatic t_mailbox;
    logic [7:0] r;
    int w0 = wn, i0 = irq_rise;
    open_tx(); xfer(8'h5A, r); xfer(8'h12, r); xfer(8'h34, r);
    xfer(8'h99, r); xfer(8'h98, r);
    close_tx();
    chk("R7 host_cmd", host_cmd, 8'h5A);
    chk("R2 R7 host_addr", host_addr, 16'h1234);
    chk("R7 data ignored", wn - w0, 0);
    chk("R7 irq", irq_rise - i0, 1);
  endtask

  task automatic t_cmd_only;
    logic [7:0] r;
    int i0 = irq_rise;
    open_tx(); xfer(8'h00, r);
    close_tx();
    chk("R10 host_cmd", host_cmd, 8'h00);
    chk("R10 host_addr kept", host_addr, 16'h1234);
    chk("R10 irq", irq_rise - i0, 1);
  endtask

  task automatic t_partial;
    logic [7:0] r;
    int w0 = wn;
    open_tx(); xfer(8'h80, r); xfer(8'h00, r); xfer(8'h20, r);
    xfer(8'h55, r); xbits(8'hF0, 4);
    close_tx();
    chk("R9 only full byte", wn - w0, 1);
    chk("R9 full byte data", wd[w0], 8'h55);
  endtask

  task automatic t_idle;
    int w0 = wn, r0 = rn, i0 = irq_rise;
    for (int k = 0; k < 10; k++) begin
      spi_mosi = k[0];
      half(); spi_sck = 1'b1;
      chk("R1 oe idle", spi_miso_oe, 1'b0);
      half(); spi_sck = 1'b0;
    end
    repeat (10) @(negedge clk);
    chk("R1 no write idle", wn - w0, 0);
    chk("R1 no read idle", rn - r0, 0);
    chk("R1 no irq idle", irq_rise - i0, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_write_quiet();
    t_read_quiet();
    t_write_wrap();
    t_read_wrap();
    t_mailbox();
    t_cmd_only();
    t_partial();
    t_idle();
    chk("R11 no overlap", both, 0);
    done = 1;
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end
endmodule